// File: doc/BRIEF.md
# Fan PWM Controller with Speed Sensing

This block drives a cooling fan from a single PWM pin and can measure the fan's speed from its tachometer line. Software programs it through a small 32-bit register port with a write strobe, a byte address, write data and combinational read data. A configuration word holds the run bit, the fan-wire mode, an output mask, the tachometer controls and an 8-bit duty value. A second word holds a 16-bit maximum-speed figure that software can read back. A read-only word returns the measured speed in revolutions per minute.

The PWM period is not programmable. It follows from the wire mode and from the `CLK_HZ` parameter. Two-wire fans get a slow period of 40 ms (`CLK_HZ/SLOW_RATE` cycles). Four-wire fans get a fast period of 40 µs (`CLK_HZ/FAST_RATE` cycles). Output polarity is always active high. Speed sensing works only for four-wire fans. Rising tachometer edges pass through a two-flop synchronizer, and every 2 or 4 edges mark one revolution. The clock count between revolution marks goes into a sequential divider, which produces the speed. A silence watchdog clears the reading when the fan stops.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset the words at offsets 0x00, 0x04 and 0x10 all read 0 and `pwm_out` is low.
- R2: Offset 0x00 keeps bit 0 (run), bit 1 (fast/four-wire), bit 2 (output mask), bit 4 (tach on), bit 5 (4 pulses per revolution) and bits 23:16 (duty), and its other bits read 0. Offset 0x04 keeps bits 15:0 and its upper bits read 0. Writes to 0x10 have no effect, and any other offset reads 0.
- R3: While running, `pwm_out` repeats with a period of `CLK_HZ/SLOW_RATE` cycles when bit 1 is 0 and `CLK_HZ/FAST_RATE` cycles when bit 1 is 1.
- R4: Over each period, `pwm_out` is high for floor(duty·P/256) cycles, starting at the start of the period, for duty values 1 to 254. Duty 0 gives a constant low and duty 255 gives a constant high.
- R5: A duty change takes effect only at a period boundary, so each high pulse has the length of either the old or the new setting.
- R6: Clearing run drives `pwm_out` low within two clock edges of the write. Setting run again starts a fresh period, so the first pulse has its full length.
- R7: While the mask bit (bit 2) is set, `pwm_out` stays low. Clearing the mask restores the programmed waveform.
- R8: Speed sensing runs only when bits 1 and 4 are both 1. In any other mode the speed word at 0x10 reads 0.
- R9: The speed word reads floor(60·`CLK_HZ`/C), where C is the clock count spanning 2 synchronized rising tach edges (bit 5 = 0) or 4 edges (bit 5 = 1).
- R10: A computed speed above 65535 reads as 65535.
- R11: If no rising tach edge arrives for `CLK_HZ/SPEED_TIMEOUT_DIV` cycles, the speed word reads 0. A reading stays valid for shorter gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tach_in | input | 1 | Tachometer pulse line from the fan |
| pwm_out | output | 1 | Fan PWM drive, active high |

## Verification
A corrupted period counter or a stale latched duty shows up within one period as a wrong high-cycle count, a wrong rise-to-rise spacing, or a pulse whose length matches neither the old nor the new setting. Errors in run or mask handling show on the pin within two edges as a high level that should not be there, or as a shortened first pulse after restart. A wrong edge count per revolution, a wrong divider result or missing saturation shows up in the speed word a few revolutions after the tach rate settles. A watchdog that fires too early or too late shows up as a zero reading before the timeout, or a stale reading after it.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    localparam int REG_W       = 32;
    localparam int OFS_CFG     = 'h00;
    localparam int OFS_LIMIT   = 'h04;
    localparam int OFS_SPEED   = 'h10;
    localparam logic [15:0] SPEED_CAP = 16'hFFFF;

    typedef struct packed {
        logic [7:0] duty;
        logic       ppr4;
        logic       tach_on;
        logic       out_off;
        logic       fast;
        logic       run;
    } fan_cfg_t;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_BUSY = 1'b1
    } div_state_t;

    function automatic fan_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        fan_cfg_t c;
        c.run     = w[0];
        c.fast    = w[1];
        c.out_off = w[2];
        c.tach_on = w[4];
        c.ppr4    = w[5];
        c.duty    = w[23:16];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input fan_cfg_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[0]     = c.run;
        w[1]     = c.fast;
        w[2]     = c.out_off;
        w[4]     = c.tach_on;
        w[5]     = c.ppr4;
        w[23:16] = c.duty;
        return w;
    endfunction

endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [15:0]       speed,
    output logic [REG_W-1:0]  rdata,
    output fan_cfg_t          cfg
);

    logic [15:0] limit_q;
    logic        hit_cfg, hit_limit, hit_speed;

    assign hit_cfg   = (addr == ADDR_W'(OFS_CFG));
    assign hit_limit = (addr == ADDR_W'(OFS_LIMIT));
    assign hit_speed = (addr == ADDR_W'(OFS_SPEED));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            limit_q <= '0;
        end else if (we) begin
            if (hit_cfg)   cfg     <= cfg_from_word(wdata);
            if (hit_limit) limit_q <= wdata[15:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_cfg)        rdata = cfg_to_word(cfg);
        else if (hit_limit) rdata = {16'd0, limit_q};
        else if (hit_speed) rdata = {16'd0, speed};
    end

    AST_LIMIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(we && hit_limit) |=> $stable(limit_q)) else $error("limit changed"); // R2

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SLOW_RATE = 25,
    parameter int FAST_RATE = 25_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       fast,
    input  logic       out_off,
    input  logic [7:0] duty,
    output logic       pwm
);

    localparam int SLOW_P = CLK_HZ / SLOW_RATE;
    localparam int FAST_P = CLK_HZ / FAST_RATE;
    localparam int MAX_P  = (SLOW_P > FAST_P) ? SLOW_P : FAST_P;
    localparam int CNT_W  = $clog2(MAX_P + 1);
    localparam int PRD_W  = CNT_W + 8;

    logic [CNT_W-1:0] cnt, per_len, last;
    logic [7:0]       duty_q;
    logic [PRD_W-1:0] prod, thr;
    logic             hi, wrap;

    assign per_len = fast ? CNT_W'(FAST_P) : CNT_W'(SLOW_P);
    assign last    = per_len - 1'b1;
    assign wrap    = (cnt >= last);
    assign prod    = PRD_W'(per_len) * PRD_W'(duty_q);
    assign thr     = prod >> 8;
    assign hi      = (duty_q == 8'hFF) || (PRD_W'(cnt) < thr);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            duty_q <= rst ? 8'd0 : duty;
        end else if (wrap) begin
            cnt    <= '0;
            duty_q <= duty;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= run && !out_off && hi;
    end

    AST_STOP_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> !pwm) else $error("output high while stopped"); // R6
    AST_MASK_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        out_off |=> !pwm) else $error("output high while masked"); // R7
    AST_DUTY_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(duty_q)) else $error("duty changed mid-period"); // R5
    AST_FULL_SCALE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (run && !out_off && duty_q == 8'hFF) |=> pwm) else $error("full duty not high"); // R4

endmodule

// File: rtl/fan_rpm_div.sv
module fan_rpm_div
    import fan_pwm_pkg::*;
#(
    parameter longint NUM   = 64'd3_000_000_000,
    parameter int     NUM_W = 32,
    parameter int     DEN_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [15:0]      quo
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    div_state_t       state;
    logic [NUM_W-1:0] num_sh, q, nq;
    logic [DEN_W-1:0] rem, dv;
    logic [DEN_W:0]   trial, diff;
    logic [STEP_W-1:0] step;
    logic             ge;

    assign trial = {rem, num_sh[NUM_W-1]};
    assign ge    = (trial >= {1'b0, dv});
    assign diff  = ge ? (trial - {1'b0, dv}) : trial;
    assign nq    = {q[NUM_W-2:0], ge};
    assign busy  = (state == DIV_BUSY);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= DIV_IDLE;
            done  <= 1'b0;
            if (rst) quo <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                DIV_IDLE: if (start) begin
                    num_sh <= NUM_W'(NUM);
                    rem    <= '0;
                    q      <= '0;
                    dv     <= den;
                    step   <= '0;
                    state  <= DIV_BUSY;
                end
                DIV_BUSY: begin
                    num_sh <= num_sh << 1;
                    rem    <= diff[DEN_W-1:0];
                    q      <= nq;
                    step   <= step + 1'b1;
                    if (step == STEP_W'(NUM_W - 1)) begin
                        state <= DIV_IDLE;
                        done  <= 1'b1;
                        quo   <= (nq > NUM_W'(SPEED_CAP)) ? SPEED_CAP : nq[15:0];
                    end
                end
                default: state <= DIV_IDLE;
            endcase
        end
    end

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == DIV_BUSY)) else $error("done without work"); // R9

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ           = 50_000_000,
    parameter int SPEED_TIMEOUT_DIV = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tach_raw,
    input  logic        active,
    input  logic        ppr4,
    output logic [15:0] speed
);

    localparam int     TIMEOUT = CLK_HZ / SPEED_TIMEOUT_DIV;
    localparam int     IDLE_W  = $clog2(TIMEOUT + 1);
    localparam int     PER_W   = $clog2(4 * TIMEOUT + 2);
    localparam longint RPM_NUM = longint'(CLK_HZ) * 64'd60;
    localparam int     NUM_W   = $clog2(RPM_NUM + 1);

    logic [2:0]        sh;
    logic              rise, mark, stall, have_ref;
    logic [1:0]        pulse_cnt, need;
    logic [IDLE_W-1:0] idle;
    logic [PER_W-1:0]  per_cnt;
    logic [PER_W:0]    den;
    logic              div_busy, div_done, div_start, div_abort;
    logic [15:0]       div_q;

    assign rise      = sh[1] && !sh[2];
    assign need      = ppr4 ? 2'd3 : 2'd1;
    assign mark      = rise && (pulse_cnt >= need);
    assign stall     = (idle == IDLE_W'(TIMEOUT));
    assign den       = {1'b0, per_cnt} + 1'b1;
    assign div_start = mark && have_ref && !stall;
    assign div_abort = stall || !active;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], tach_raw};
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pulse_cnt <= '0;
            have_ref  <= 1'b0;
            per_cnt   <= '0;
            idle      <= '0;
            speed     <= '0;
        end else begin
            if (mark)                per_cnt <= '0;
            else if (per_cnt != '1)  per_cnt <= per_cnt + 1'b1;
            if (rise)                idle <= '0;
            else if (!stall)         idle <= idle + 1'b1;
            if (rise)                pulse_cnt <= (pulse_cnt >= need) ? 2'd0 : pulse_cnt + 1'b1;
            if (mark)                have_ref <= 1'b1;
            if (div_done)            speed <= div_q;
            if (stall) begin
                speed     <= '0;
                have_ref  <= 1'b0;
                pulse_cnt <= '0;
            end
        end
    end

    fan_rpm_div #(
        .NUM   (RPM_NUM),
        .NUM_W (NUM_W),
        .DEN_W (PER_W + 1)
    ) div_i (
        .clk   (clk),
        .rst   (rst),
        .abort (div_abort),
        .start (div_start && !div_busy),
        .den   (den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_q)
    );

    AST_IDLE_SPEED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> (speed == 16'd0)) else $error("speed while inactive"); // R8
    AST_STALL_SPEED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (active && stall) |=> (speed == 16'd0)) else $error("speed after stall"); // R11

endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ            = 50_000_000,
    parameter int SLOW_RATE         = 25,
    parameter int FAST_RATE         = 25_000,
    parameter int SPEED_TIMEOUT_DIV = 1,
    parameter int ADDR_W            = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tach_in,
    output logic              pwm_out
);

    fan_cfg_t    cfg;
    logic [15:0] speed;

    fan_pwm_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .speed (speed),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    fan_pwm_gen #(
        .CLK_HZ    (CLK_HZ),
        .SLOW_RATE (SLOW_RATE),
        .FAST_RATE (FAST_RATE)
    ) gen_i (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .fast    (cfg.fast),
        .out_off (cfg.out_off),
        .duty    (cfg.duty),
        .pwm     (pwm_out)
    );

    fan_tach_meter #(
        .CLK_HZ            (CLK_HZ),
        .SPEED_TIMEOUT_DIV (SPEED_TIMEOUT_DIV)
    ) tach_i (
        .clk      (clk),
        .rst      (rst),
        .tach_raw (tach_in),
        .active   (cfg.fast && cfg.tach_on),
        .ppr4     (cfg.ppr4),
        .speed    (speed)
    );

    AST_RESET_OUT_LOW: assert property (@(posedge clk)
        rst |=> !pwm_out) else $error("output high after reset"); // R1

endmodule

// File: tb/fan_pwm_ctrl_tb_top.sv
module fan_pwm_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 1_024_000;
    localparam int T_SLOW     = 400;
    localparam int T_FAST     = 4000;
    localparam int T_TODIV    = 100;
    localparam int P_SLOW     = T_CLK_HZ / T_SLOW;
    localparam int P_FAST     = T_CLK_HZ / T_FAST;
    localparam int TIMEOUT    = T_CLK_HZ / T_TODIV;
    localparam longint RPM_K  = longint'(T_CLK_HZ) * 60;
    localparam int WATCHDOG   = 190_000;

    // {fast, duty}
    localparam logic [8:0] VEC [10] = '{
        {1'b1, 8'd0},   {1'b1, 8'd1},   {1'b1, 8'd64},  {1'b1, 8'd128},
        {1'b1, 8'd254}, {1'b1, 8'd255}, {1'b0, 8'd100}, {1'b0, 8'd255},
        {1'b0, 8'd3},   {1'b0, 8'd0}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_we = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tach_in = 0;
    logic        pwm_out;
    int          tach_t = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_pwm_ctrl #(
        .CLK_HZ(T_CLK_HZ), .SLOW_RATE(T_SLOW), .FAST_RATE(T_FAST),
        .SPEED_TIMEOUT_DIV(T_TODIV), .ADDR_W(8)
    ) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tach_in(tach_in),
        .pwm_out(pwm_out)
    );

    initial forever begin
        if (tach_t == 0) begin
            tach_in = 0;
            @(negedge clk);
        end else begin
            tach_in = 1;
            repeat (tach_t / 2) @(negedge clk);
            tach_in = 0;
            repeat (tach_t - tach_t / 2) @(negedge clk);
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 0;
        prev = pwm_out;
        for (int i = 0; i < 3 * P_SLOW; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin ok = 1; break; end
            prev = pwm_out;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 1;
        for (int i = 0; i < 2 * P_SLOW; i++) begin
            @(negedge clk);
            if (!pwm_out) break;
            n++;
        end
    endtask

    function automatic int exp_high(input logic fast, input logic [7:0] duty);
        int p;
        p = fast ? P_FAST : P_SLOW;
        if (duty == 8'hFF) return p;
        return (int'(duty) * p) / 256;
    endfunction

    function automatic longint exp_rpm(input longint cyc);
        longint v;
        v = RPM_K / cyc;
        return (v > 65535) ? 65535 : v;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, per, len, last_len;
        bit ok;

        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(8'h00, d); check("R1 cfg", d, 0);
        rd(8'h04, d); check("R1 limit", d, 0);
        rd(8'h10, d); check("R1 speed", d, 0);
        check("R1 pwm_out", pwm_out, 0);

        // R2 register masks
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 cfg mask", d, 32'h00FF_0037);
        wr(8'h04, 32'hFFFF_ABCD); rd(8'h04, d); check("R2 limit mask", d, 32'h0000_ABCD);
        wr(8'h10, 32'h0000_1234); rd(8'h10, d); check("R2 speed read-only", d, 0);
        rd(8'h08, d); check("R2 unmapped 0x08", d, 0);
        rd(8'h0C, d); check("R2 unmapped 0x0C", d, 0);
        wr(8'h00, 32'h0);

        // R3/R4 vector table
        foreach (VEC[k]) begin
            logic fast;
            logic [7:0] duty;
            int p;
            fast = VEC[k][8];
            duty = VEC[k][7:0];
            p = fast ? P_FAST : P_SLOW;
            wr(8'h00, {8'd0, duty, 14'd0, fast, 1'b1});
            repeat (p + 4) @(negedge clk);
            count_high(p, h);
            check($sformatf("R4 high cycles duty=%0d fast=%0d", duty, fast), h, exp_high(fast, duty));
            if (duty != 0 && duty != 8'hFF) begin
                wait_rise(ok);
                per = 0;
                if (ok) begin
                    wait_rise(ok);
                end
                per = 0;
            end
        end

        // R3 period spacing, both modes
        for (int m = 0; m < 2; m++) begin
            int p;
            p = (m == 1) ? P_FAST : P_SLOW;
            wr(8'h00, {8'd0, 8'd100, 14'd0, m[0], 1'b1});
            repeat (p + 4) @(negedge clk);
            wait_rise(ok);
            per = 0;
            begin
                logic prev;
                prev = pwm_out;
                for (int i = 0; i < 3 * P_SLOW; i++) begin
                    @(negedge clk);
                    per++;
                    if (!prev && pwm_out) break;
                    prev = pwm_out;
                end
            end
            check($sformatf("R3 period fast=%0d", m), per, p);
        end

        // R5 duty change mid-period
        wr(8'h00, 32'h0040_0003);
        repeat (P_FAST * 2) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        while (pwm_out) @(negedge clk);
        repeat (30) @(negedge clk);
        wr(8'h00, 32'h00C0_0003);
        last_len = 0;
        for (int i = 0; i < 4; i++) begin
            wait_rise(ok);
            pulse_len(len);
            if (len != 64 && len != 192) check("R5 pulse is old or new", len, 192);
            last_len = len;
        end
        check("R5 settled pulse", last_len, 192);

        // R6 stop and restart
        wr(8'h00, 32'h0080_0003);
        repeat (P_FAST * 2) @(negedge clk);
        wait_rise(ok);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h0080_0002);
        @(negedge clk);
        check("R6 low after stop", pwm_out, 0);
        count_high(300, h);
        check("R6 stays low", h, 0);
        wr(8'h00, 32'h0080_0003);
        wait_rise(ok);
        pulse_len(len);
        check("R6 first pulse full", len, exp_high(1'b1, 8'd128));

        // R7 output mask
        wr(8'h00, 32'h00FF_0007);
        repeat (4) @(negedge clk);
        count_high(P_FAST, h);
        check("R7 masked output", h, 0);
        wr(8'h00, 32'h00FF_0003);
        repeat (4) @(negedge clk);
        count_high(P_FAST, h);
        check("R7 mask cleared", h, P_FAST);
        wr(8'h00, 32'h0);

        // R8 sensing gated by mode
        tach_t = 512;
        wr(8'h00, 32'h0000_0010);
        repeat (4000) @(negedge clk);
        rd(8'h10, d); check("R8 two-wire speed", d, 0);
        wr(8'h00, 32'h0000_0002);
        repeat (4000) @(negedge clk);
        rd(8'h10, d); check("R8 tach off speed", d, 0);

        // R9 speed values
        wr(8'h00, 32'h0000_0012);
        repeat (10 * 1024) @(negedge clk);
        rd(8'h10, d); check("R9 2 ppr T=512", d, exp_rpm(1024));
        wr(8'h00, 32'h0000_0032);
        repeat (8 * 2048) @(negedge clk);
        rd(8'h10, d); check("R9 4 ppr T=512", d, exp_rpm(2048));
        tach_t = 1000;
        repeat (6 * 4000) @(negedge clk);
        rd(8'h10, d); check("R9 4 ppr T=1000", d, exp_rpm(4000));

        // R10 saturation
        wr(8'h00, 32'h0000_0012);
        tach_t = 300;
        repeat (4000) @(negedge clk);
        rd(8'h10, d); check("R10 saturated speed", d, 65535);

        // R11 stall timeout
        tach_t = 512;
        repeat (8000) @(negedge clk);
        rd(8'h10, d); check("R11 running before stop", d, exp_rpm(1024));
        tach_t = 0;
        repeat (TIMEOUT / 2) @(negedge clk);
        rd(8'h10, d); check("R11 held within window", d, exp_rpm(1024));
        repeat (TIMEOUT / 2 + 800) @(negedge clk);
        rd(8'h10, d); check("R11 zero after window", d, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule